// File: doc/BRIEF.md
# Hash-Keyed Pad Stream Cipher

This block encrypts or decrypts a short byte message with a keystream taken from a 160-bit hash digest. The secret stays inside an external hash engine. The block only forwards a per-message random challenge, plus a chunk number, to that engine. It then XORs each message byte with the next byte of the returned digest. Each digest yields twenty pad bytes. When those are used up, the block issues a new request with the next chunk number, so a message of up to 255 bytes never repeats a pad byte.

In encrypt mode the caller supplies the challenge with the start pulse. The output frame is the three challenge bytes followed by the ciphertext. In decrypt mode the first three bytes of the input stream are taken as the challenge and are not forwarded. The same digests are then requested, and the remaining bytes are XORed back to plaintext. Data moves on byte streams with valid/ready. In the data phase the output valid follows the input valid, and the input ready follows the output ready, so each byte passes through in the cycle it is offered.

Top module: `pad_cipher`

## Requirements
- R1: After reset `busy`, `out_valid`, `in_ready` and `hash_req_valid` are all 0, and all three handshake outputs stay 0 whenever `busy` is 0.
- R2: A `start` sampled while idle raises `busy` at the next clock edge. `busy` falls at the edge that completes the last transfer of the frame.
- R3: `start` pulses while `busy` is 1 are ignored: the running frame's output bytes and hash requests are unchanged.
- R4: With `mode`=0 (encrypt), the frame begins with the 24-bit challenge sent as three bytes, bits [23:16] first, followed by `msg_len` ciphertext bytes.
- R5: Message byte k (counting from 0) is XORed with pad byte k. Pad byte k is byte (k mod 20) of the digest for chunk k/20, taking digest bits [159:152] as byte 0.
- R6: With `mode`=1 (decrypt), the first three input bytes are accepted without any output and form the challenge, bits [23:16] first. The following `msg_len` bytes are output XORed with the pad of R5.
- R7: Chunk 0 is requested after the challenge phase. After every 20 data bytes, if bytes remain, a new request carries the next chunk number. Every request carries the frame's challenge, so a frame issues ceil(`msg_len`/20) requests.
- R8: From the moment a request is raised until its digest arrives, `in_ready` and `out_valid` are 0.
- R9: With `msg_len`=0 no hash request is made. Encrypt emits only the challenge, and decrypt only consumes it.
- R10: `out_last` is 1 exactly on the final output byte of a frame.
- R11: A raised `hash_req_valid` holds, with its challenge and chunk number unchanged, until `hash_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| mode | input | 1 | 0 encrypt, 1 decrypt; sampled with start |
| msg_len | input | 8 | Message byte count, sampled with start |
| challenge | input | 24 | Random challenge for encrypt, sampled with start |
| busy | output | 1 | Frame in progress |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte taken |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of frame |
| hash_req_valid | output | 1 | Digest request raised |
| hash_req_ready | input | 1 | Request taken by hash engine |
| hash_req_chal | output | 24 | Challenge for the request |
| hash_req_idx | output | 8 | Chunk number for the request |
| hash_rsp_valid | input | 1 | Digest available |
| hash_rsp_digest | input | 160 | 160-bit digest |

## Verification
`busy` is due one edge after an accepted start and drops one edge after the final transfer. The bench samples it at the falling edge that follows each of those edges. Output bytes in the data phase depend combinationally on the input byte and on the pad register, so each is compared in the same half cycle in which it is offered, just before the edge that takes it. The stand-in hash engine delays its ready by two cycles and its digest by three. A request must therefore stay unchanged across the wait, and the streams must stay stalled for that window; both are checked at every falling edge.

// File: rtl/pad_cipher.sv
module pad_cipher #(
  parameter int CHAL_BYTES = 3,
  parameter int DIG_BYTES  = 20,
  parameter int LEN_W      = 8,
  parameter int IDX_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   mode,
  input  logic [LEN_W-1:0]       msg_len,
  input  logic [8*CHAL_BYTES-1:0] challenge,
  output logic                   busy,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_last,
  output logic                   hash_req_valid,
  input  logic                   hash_req_ready,
  output logic [8*CHAL_BYTES-1:0] hash_req_chal,
  output logic [IDX_W-1:0]       hash_req_idx,
  input  logic                   hash_rsp_valid,
  input  logic [8*DIG_BYTES-1:0] hash_rsp_digest
);
  localparam int CHAL_W = 8 * CHAL_BYTES;
  localparam int DIG_W  = 8 * DIG_BYTES;
  localparam int CB_W   = $clog2(CHAL_BYTES + 1);
  localparam int PB_W   = $clog2(DIG_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CHAL, S_HREQ, S_HWAIT, S_DATA} st_t;

  st_t               st;
  logic              dec_r;
  logic [LEN_W-1:0]  rem;
  logic [CHAL_W-1:0] chal_r;
  logic [CB_W-1:0]   cidx;
  logic [PB_W-1:0]   pidx;
  logic [IDX_W-1:0]  chunk;
  logic [DIG_W-1:0]  pad_r;

  wire in_chal   = (st == S_CHAL);
  wire in_data_p = (st == S_DATA);
  wire chal_last = (cidx == CB_W'(CHAL_BYTES - 1));
  wire chal_fire = in_chal && (dec_r ? in_valid : out_ready);
  wire data_fire = in_data_p && in_valid && out_ready;

  assign busy           = (st != S_IDLE);
  assign in_ready       = (in_chal && dec_r) || (in_data_p && out_ready);
  assign out_valid      = (in_chal && !dec_r) || (in_data_p && in_valid);
  assign out_data       = in_data_p ? (in_data ^ pad_r[DIG_W-1 -: 8])
                                    : chal_r[(CHAL_BYTES - 1 - int'(cidx)) * 8 +: 8];
  assign out_last       = (in_data_p && rem == LEN_W'(1)) ||
                          (in_chal && !dec_r && chal_last && rem == '0);
  assign hash_req_valid = (st == S_HREQ);
  assign hash_req_chal  = chal_r;
  assign hash_req_idx   = chunk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dec_r  <= 1'b0;
      rem    <= '0;
      chal_r <= '0;
      cidx   <= '0;
      pidx   <= '0;
      chunk  <= '0;
      pad_r  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dec_r  <= mode;
          rem    <= msg_len;
          chal_r <= challenge;
          cidx   <= '0;
          chunk  <= '0;
          st     <= S_CHAL;
        end
        S_CHAL: if (chal_fire) begin
          cidx <= cidx + 1'b1;
          if (dec_r) chal_r <= (chal_r << 8) | CHAL_W'(in_data);
          if (chal_last) st <= (rem == '0) ? S_IDLE : S_HREQ;
        end
        S_HREQ: if (hash_req_ready) st <= S_HWAIT;
        S_HWAIT: if (hash_rsp_valid) begin
          pad_r <= hash_rsp_digest;
          pidx  <= '0;
          st    <= S_DATA;
        end
        S_DATA: if (data_fire) begin
          pad_r <= pad_r << 8;
          pidx  <= pidx + 1'b1;
          rem   <= rem - 1'b1;
          if (rem == LEN_W'(1)) st <= S_IDLE;
          else if (pidx == PB_W'(DIG_BYTES - 1)) begin
            chunk <= chunk + 1'b1;
            st    <= S_HREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready && !hash_req_valid));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !busy);

  p_req_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_req_valid && hash_req_ready) |=> !hash_req_valid);

  p_req_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hash_req_valid |-> (!in_ready && !out_valid));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_req_valid && !hash_req_ready) |=>
      (hash_req_valid && $stable(hash_req_chal) && $stable(hash_req_idx)));
endmodule

// File: tb/pad_cipher_bench.sv
module pad_cipher_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic [7:0] msg_len = '0;
  logic [23:0] challenge = '0;
  logic busy;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [7:0] out_data;
  logic hash_req_valid, hash_req_ready = 1'b0;
  logic [23:0] hash_req_chal;
  logic [7:0] hash_req_idx;
  logic hash_rsp_valid = 1'b0;
  logic [159:0] hash_rsp_digest = '0;

  always #5 clk = ~clk;

  pad_cipher u_pad_cipher (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .msg_len(msg_len),
    .challenge(challenge), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .hash_req_valid(hash_req_valid),
    .hash_req_ready(hash_req_ready), .hash_req_chal(hash_req_chal),
    .hash_req_idx(hash_req_idx), .hash_rsp_valid(hash_rsp_valid),
    .hash_rsp_digest(hash_rsp_digest));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [159:0] model_dig(input logic [23:0] c, input logic [7:0] k);
    logic [159:0] d;
    for (int w = 0; w < 5; w++)
      d[32*w +: 32] = ({c, k} * 32'h9E3779B1) + (w * 32'h7F4A7C15) ^ 32'hC3A5_5A3C ^ {k, c};
    return d;
  endfunction

  function automatic logic [7:0] pad_byte(input logic [23:0] c, input int p);
    logic [159:0] d;
    d = model_dig(c, 8'(p / 20));
    return d[159 - 8 * (p % 20) -: 8];
  endfunction

  int hold_cnt = 0, wait_cnt = 0, req_count = 0, exp_chunk = 0;
  bit outstanding = 1'b0, prev_wait = 1'b0;
  logic [23:0] frame_chal = '0, lat_c = '0, prev_c = '0;
  logic [7:0] lat_k = '0, prev_k = '0;

  always begin
    @(negedge clk);
    hash_rsp_valid = 1'b0;
    if (wait_cnt == 0) outstanding = 1'b0;
    if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        hash_rsp_valid  = 1'b1;
        hash_rsp_digest = model_dig(lat_c, lat_k);
      end
    end
    if (hash_req_valid) begin
      hold_cnt++;
      hash_req_ready = (hold_cnt >= 3);
    end else begin
      hold_cnt = 0;
      hash_req_ready = 1'b0;
    end
    #1;
    if (prev_wait)
      chk(hash_req_valid && hash_req_chal == prev_c && hash_req_idx == prev_k,
          "R11 request hold", {hash_req_valid, hash_req_chal, hash_req_idx[6:0]},
          {1'b1, prev_c, prev_k[6:0]});
    prev_wait = hash_req_valid && !hash_req_ready;
    prev_c = hash_req_chal;
    prev_k = hash_req_idx;
    if (hash_req_valid || outstanding)
      chk(!in_ready && !out_valid, "R8 stall", {in_ready, out_valid}, 0);
    if (hash_req_valid && hash_req_ready) begin
      chk(hash_req_chal == frame_chal && hash_req_idx == 8'(exp_chunk), "R7 request",
          {hash_req_chal, hash_req_idx}, {frame_chal, 8'(exp_chunk)});
      exp_chunk++;
      req_count++;
      lat_c = hash_req_chal;
      lat_k = hash_req_idx;
      wait_cnt = 3;
      outstanding = 1'b1;
    end
  end

  task automatic run_frame(input bit dec, input logic [23:0] ch, input logic [7:0] len,
                           input logic [7:0] seed, input bit bp, input bit poke, input string tag);
    logic [7:0] inb [0:300];
    logic [7:0] expb [0:300];
    int n_in, n_exp, ii, oi, cyc;
    logic [7:0] m;
    for (int i = 0; i < 3; i++) begin
      inb[i]  = ch[23 - 8*i -: 8];
      expb[i] = ch[23 - 8*i -: 8];
    end
    for (int i = 0; i < int'(len); i++) begin
      m = seed ^ 8'(i * 37);
      if (dec) begin
        inb[3 + i] = m ^ pad_byte(ch, i);
        expb[i]    = m;
      end else begin
        inb[i]      = m;
        expb[3 + i] = m ^ pad_byte(ch, i);
      end
    end
    n_in  = dec ? 3 + int'(len) : int'(len);
    n_exp = dec ? int'(len) : 3 + int'(len);
    frame_chal = ch;
    exp_chunk = 0;
    req_count = 0;
    @(negedge clk);
    start = 1'b1; mode = dec; msg_len = len; challenge = ch;
    @(negedge clk);
    start = 1'b0;
    ii = 0; oi = 0; cyc = 0;
    while ((ii < n_in || oi < n_exp) && cyc < 3000) begin
      in_valid  = (ii < n_in);
      in_data   = (ii < n_in) ? inb[ii] : 8'h00;
      out_ready = bp ? (cyc % 3 != 2) : 1'b1;
      if (poke && cyc == 4) begin
        start = 1'b1; mode = !dec; msg_len = len + 8'd5; challenge = ~ch;
      end else start = 1'b0;
      #1;
      if (cyc == 0) chk(busy, "R2 busy after start", busy, 1);
      if (out_valid && out_ready) begin
        chk(out_data == expb[oi], tag, out_data, expb[oi]);
        chk(out_last == (oi == n_exp - 1), "R10 last flag", out_last, oi == n_exp - 1);
        oi++;
      end
      if (in_valid && in_ready) ii++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    in_valid = 1'b0;
    #1;
    chk(cyc < 3000, "frame completion", cyc, 3000);
    chk(!busy && !out_valid, "R2 busy clear at end", {busy, out_valid}, 0);
    chk(req_count == (int'(len) + 19) / 20, "R7 R9 request count", req_count, (int'(len) + 19) / 20);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !out_valid && !in_ready && !hash_req_valid, "R1 reset state",
        {busy, out_valid, in_ready, hash_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !out_valid && !in_ready, "R1 idle quiet", {busy, out_valid, in_ready}, 0);
  endtask

  task automatic t_enc_short();  run_frame(1'b0, 24'hA1B2C3, 8'd5, 8'h11, 1'b0, 1'b0, "R4 R5 encrypt short"); endtask
  task automatic t_dec_short();  run_frame(1'b1, 24'h0F1E2D, 8'd7, 8'h42, 1'b0, 1'b0, "R6 decrypt short"); endtask
  task automatic t_enc_long();   run_frame(1'b0, 24'h123456, 8'd45, 8'h5C, 1'b1, 1'b0, "R5 R7 encrypt multi-chunk"); endtask
  task automatic t_dec_bound();  run_frame(1'b1, 24'hFEDCBA, 8'd40, 8'h99, 1'b1, 1'b0, "R6 R7 decrypt chunk boundary"); endtask
  task automatic t_zero_enc();   run_frame(1'b0, 24'h77AA55, 8'd0, 8'h00, 1'b0, 1'b0, "R9 encrypt zero length"); endtask
  task automatic t_zero_dec();   run_frame(1'b1, 24'h3C3C3C, 8'd0, 8'h00, 1'b0, 1'b0, "R9 decrypt zero length"); endtask
  task automatic t_busy_start(); run_frame(1'b0, 24'h600DF0, 8'd12, 8'h21, 1'b0, 1'b1, "R3 start ignored while busy"); endtask
  task automatic t_max_len();    run_frame(1'b0, 24'h0BEEF1, 8'd255, 8'hE7, 1'b0, 1'b0, "R5 R7 maximum length"); endtask

  initial begin
    #(2_000_000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_enc_short();
    t_dec_short();
    t_enc_long();
    t_dec_bound();
    t_zero_enc();
    t_zero_dec();
    t_busy_start();
    t_max_len();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule